// File: doc/BRIEF.md
# Dual-Module Serial DAC Code Front End

This block is the digital front end of a composite converter with two identical, independent modules. Each module has a main serial port and a reference serial port. The main port collects a 16-bit word. One rising edge of its load strobe turns that word into two 8-bit output codes, X and Y, with no address field. The reference port has its own clock, data and load pins. It collects an 8-bit word that becomes the reference-adjust code. The block drives only the latched codes; the analog converters that use them sit outside it.

Every serial clock, data, load and reset pin is brought into a fast system clock domain through two-flop synchronizers. Rising edges are found from the synchronized samples. The system clock must run at least four times faster than the serial clock. The serial pins are raw wires, so they carry no valid/ready handshake and offer no back-pressure. The host must keep each data bit stable around its clock edge and must space edges at least three system clocks apart. Two resets lead to the same state: an asynchronous power-on reset, and a synchronized external reset that all modules share. In that state the main codes are 00h and the reference code is FFh.

Top module: `dacfe_top`

## Requirements
- R1: A main word is 16 bits sent MSB first; the first bit shifted ends up as bit 7 of code X and the last bit as bit 0 of code Y.
- R2: The reference word is 8 bits sent MSB first on its own clock, data and load pins, and it is transferred only by a rising edge of its own load pin.
- R3: Each rising edge of a serial clock shifts exactly one data bit into that port's shift register; falling edges shift nothing.
- R4: On a rising edge of the main load pin, word bits 15..8 become code X and bits 7..0 become code Y, both in the same system clock cycle, no more than three system clocks after the pin edge.
- R5: With no load rising edge, the codes keep their values while bits are being shifted in and while a load pin stays at a steady level.
- R6: While the external reset pin is low, every code X and code Y reads 00h and every reference code reads FFh, and load edges are ignored.
- R7: After reset is released, the reset codes stay unchanged until a load rising edge, even when serial clocks arrive.
- R8: The two modules are independent: shifting into or loading one module never changes the codes of the other.
- R9: The power-on reset leaves the same code state as R6.
- R10: A load leaves the shift register as it is: if more bits than the word length are shifted, only the most recent 16 (or 8) count, and a second load with no new clocks repeats the same codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock, at least 4x the serial clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | Shared external reset pin, active low, synchronized |
| main_sck | input | NUM_MOD | Main-port serial clock, one bit per module |
| main_sdi | input | NUM_MOD | Main-port serial data, one bit per module |
| main_ld | input | NUM_MOD | Main-port load strobe, rising edge active |
| ref_sck | input | NUM_MOD | Reference-port serial clock, one bit per module |
| ref_sdi | input | NUM_MOD | Reference-port serial data, one bit per module |
| ref_ld | input | NUM_MOD | Reference-port load strobe, rising edge active |
| code_x | output | NUM_MOD*8 | X-side codes; module m occupies bits [8m+7:8m] |
| code_y | output | NUM_MOD*8 | Y-side codes, same packing |
| code_ref | output | NUM_MOD*8 | Reference-adjust codes, same packing |

## Verification
The hardest state to reach from the ports is a shift register that holds more than one word's worth of history. Here a load copies the most recent bits, and the earlier bits must not leak into the result. The stimulus reaches it two ways. It shifts a 24-bit stream before a load, and it adds a few bits on top of an already loaded word and then loads again. It also pulses load strobes while the external reset is held, and it clocks in bits after release without a load, which shows that neither event moves the codes. A vector table runs each word through one module while the bench checks that the other module keeps its codes.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int CODE_W_DEF   = 8;
  localparam int NUM_MOD_DEF  = 2;
  localparam int SYNC_DEF     = 2;

  // positions inside the per-module strobe bundle
  localparam int STB_MAIN_SCK = 0;
  localparam int STB_MAIN_LD  = 1;
  localparam int STB_REF_SCK  = 2;
  localparam int STB_REF_LD   = 3;
  localparam int STB_N        = 4;

  // positions inside the per-module data bundle
  localparam int DAT_MAIN     = 0;
  localparam int DAT_REF      = 1;
  localparam int DAT_N        = 2;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter bit            EDGE    = 1'b0,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int k = 0; k < STAGES; k++) pipe[k] <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  generate
    if (EDGE) begin : g_edge
      logic [W-1:0] prev;
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) prev <= RST_VAL;
        else        prev <= pipe[STAGES-1];
      end
      assign q = pipe[STAGES-1] & ~prev;
    end else begin : g_level
      assign q = pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dacfe_shiftload.sv
module dacfe_shiftload #(
  parameter int           W       = 16,
  parameter logic [W-1:0] OUT_RST = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         bit_in,
  input  logic         load_en,
  output logic [W-1:0] sh_q,
  output logic [W-1:0] word_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sh_q   <= '0;
      word_q <= OUT_RST;
    end else if (clr) begin
      sh_q   <= '0;
      word_q <= OUT_RST;
    end else begin
      if (shift_en) sh_q   <= {sh_q[W-2:0], bit_in};
      if (load_en)  word_q <= sh_q;
    end
  end
endmodule

// File: rtl/dacfe_module.sv
module dacfe_module
  import dacfe_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  parameter int STAGES = SYNC_DEF
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                clr,
  input  logic                main_sck,
  input  logic                main_sdi,
  input  logic                main_ld,
  input  logic                ref_sck,
  input  logic                ref_sdi,
  input  logic                ref_ld,
  output logic [CODE_W-1:0]   code_x,
  output logic [CODE_W-1:0]   code_y,
  output logic [CODE_W-1:0]   code_ref,
  output logic [2*CODE_W-1:0] main_sh,
  output logic [CODE_W-1:0]   ref_sh,
  output logic [STB_N-1:0]    stb_rise,
  output logic [DAT_N-1:0]    dat_lvl
);
  localparam int MAIN_W = 2 * CODE_W;

  logic [STB_N-1:0]  stb_raw;
  logic [DAT_N-1:0]  dat_raw;
  logic [MAIN_W-1:0] main_word;

  always_comb begin
    stb_raw = '0;
    stb_raw[STB_MAIN_SCK] = main_sck;
    stb_raw[STB_MAIN_LD]  = main_ld;
    stb_raw[STB_REF_SCK]  = ref_sck;
    stb_raw[STB_REF_LD]   = ref_ld;
    dat_raw = '0;
    dat_raw[DAT_MAIN]     = main_sdi;
    dat_raw[DAT_REF]      = ref_sdi;
  end

  dacfe_sync #(.W(STB_N), .STAGES(STAGES), .EDGE(1'b1), .RST_VAL('0)) u_stb (
    .clk(clk), .por_n(por_n), .din(stb_raw), .q(stb_rise));

  dacfe_sync #(.W(DAT_N), .STAGES(STAGES), .EDGE(1'b0), .RST_VAL('0)) u_dat (
    .clk(clk), .por_n(por_n), .din(dat_raw), .q(dat_lvl));

  dacfe_shiftload #(.W(MAIN_W), .OUT_RST('0)) u_main (
    .clk(clk), .por_n(por_n), .clr(clr),
    .shift_en(stb_rise[STB_MAIN_SCK]), .bit_in(dat_lvl[DAT_MAIN]),
    .load_en(stb_rise[STB_MAIN_LD]),
    .sh_q(main_sh), .word_q(main_word));

  dacfe_shiftload #(.W(CODE_W), .OUT_RST('1)) u_ref (
    .clk(clk), .por_n(por_n), .clr(clr),
    .shift_en(stb_rise[STB_REF_SCK]), .bit_in(dat_lvl[DAT_REF]),
    .load_en(stb_rise[STB_REF_LD]),
    .sh_q(ref_sh), .word_q(code_ref));

  assign code_x = main_word[MAIN_W-1:CODE_W];
  assign code_y = main_word[CODE_W-1:0];
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int NUM_MOD = NUM_MOD_DEF,
  parameter int CODE_W  = CODE_W_DEF,
  parameter int STAGES  = SYNC_DEF
) (
  input  logic                      clk,
  input  logic                      por_n,
  input  logic                      ext_rst_n,
  input  logic [NUM_MOD-1:0]        main_sck,
  input  logic [NUM_MOD-1:0]        main_sdi,
  input  logic [NUM_MOD-1:0]        main_ld,
  input  logic [NUM_MOD-1:0]        ref_sck,
  input  logic [NUM_MOD-1:0]        ref_sdi,
  input  logic [NUM_MOD-1:0]        ref_ld,
  output logic [NUM_MOD*CODE_W-1:0] code_x,
  output logic [NUM_MOD*CODE_W-1:0] code_y,
  output logic [NUM_MOD*CODE_W-1:0] code_ref
);
  localparam int MAIN_W = 2 * CODE_W;

  logic                       ext_lvl;
  logic                       rst_act;
  logic [NUM_MOD*MAIN_W-1:0]  main_sh_all;
  logic [NUM_MOD*CODE_W-1:0]  ref_sh_all;
  logic [NUM_MOD-1:0]         main_sck_r, main_ld_r, ref_sck_r, ref_ld_r;
  logic [NUM_MOD-1:0]         main_bit, ref_bit;

  // external reset synchronizer powers up in the asserted state
  dacfe_sync #(.W(1), .STAGES(STAGES), .EDGE(1'b0), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .por_n(por_n), .din(ext_rst_n), .q(ext_lvl));
  assign rst_act = ~ext_lvl;

  generate
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
      logic [STB_N-1:0] stb_rise;
      logic [DAT_N-1:0] dat_lvl;

      dacfe_module #(.CODE_W(CODE_W), .STAGES(STAGES)) u_mod (
        .clk(clk), .por_n(por_n), .clr(rst_act),
        .main_sck(main_sck[m]), .main_sdi(main_sdi[m]), .main_ld(main_ld[m]),
        .ref_sck(ref_sck[m]), .ref_sdi(ref_sdi[m]), .ref_ld(ref_ld[m]),
        .code_x(code_x[m*CODE_W +: CODE_W]),
        .code_y(code_y[m*CODE_W +: CODE_W]),
        .code_ref(code_ref[m*CODE_W +: CODE_W]),
        .main_sh(main_sh_all[m*MAIN_W +: MAIN_W]),
        .ref_sh(ref_sh_all[m*CODE_W +: CODE_W]),
        .stb_rise(stb_rise), .dat_lvl(dat_lvl));

      assign main_sck_r[m] = stb_rise[STB_MAIN_SCK];
      assign main_ld_r[m]  = stb_rise[STB_MAIN_LD];
      assign ref_sck_r[m]  = stb_rise[STB_REF_SCK];
      assign ref_ld_r[m]   = stb_rise[STB_REF_LD];
      assign main_bit[m]   = dat_lvl[DAT_MAIN];
      assign ref_bit[m]    = dat_lvl[DAT_REF];
    end
  endgenerate
endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
  parameter int NUM_MOD = 2,
  parameter int CODE_W  = 8
) (
  input logic                        clk,
  input logic                        por_n,
  input logic                        rst_act,
  input logic [NUM_MOD*CODE_W-1:0]   code_x,
  input logic [NUM_MOD*CODE_W-1:0]   code_y,
  input logic [NUM_MOD*CODE_W-1:0]   code_ref,
  input logic [NUM_MOD*2*CODE_W-1:0] main_sh,
  input logic [NUM_MOD*CODE_W-1:0]   ref_sh,
  input logic [NUM_MOD-1:0]          main_sck_r,
  input logic [NUM_MOD-1:0]          main_ld_r,
  input logic [NUM_MOD-1:0]          ref_sck_r,
  input logic [NUM_MOD-1:0]          ref_ld_r,
  input logic [NUM_MOD-1:0]          main_bit,
  input logic [NUM_MOD-1:0]          ref_bit
);
  localparam int MW = 2 * CODE_W;

  generate
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_chk
      assert_load_split_R4: assert property (@(posedge clk) disable iff (!por_n)
        (main_ld_r[m] && !rst_act) |=>
          (code_x[m*CODE_W +: CODE_W] == $past(main_sh[m*MW+CODE_W +: CODE_W])) &&
          (code_y[m*CODE_W +: CODE_W] == $past(main_sh[m*MW +: CODE_W])));

      assert_ref_load_R2: assert property (@(posedge clk) disable iff (!por_n)
        (ref_ld_r[m] && !rst_act) |=>
          (code_ref[m*CODE_W +: CODE_W] == $past(ref_sh[m*CODE_W +: CODE_W])));

      assert_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
        (!main_ld_r[m] && !ref_ld_r[m] && !rst_act) |=>
          ($stable(code_x[m*CODE_W +: CODE_W]) && $stable(code_y[m*CODE_W +: CODE_W]) &&
           $stable(code_ref[m*CODE_W +: CODE_W])));

      assert_shift_R3: assert property (@(posedge clk) disable iff (!por_n)
        (main_sck_r[m] && !rst_act) |=>
          (main_sh[m*MW +: MW] == {$past(main_sh[m*MW +: MW-1]), $past(main_bit[m])}));

      assert_ref_shift_R3: assert property (@(posedge clk) disable iff (!por_n)
        (ref_sck_r[m] && !rst_act) |=>
          (ref_sh[m*CODE_W +: CODE_W] ==
           {$past(ref_sh[m*CODE_W +: CODE_W-1]), $past(ref_bit[m])}));

      assert_reset_codes_R6: assert property (@(posedge clk) disable iff (!por_n)
        rst_act |=>
          (code_x[m*CODE_W +: CODE_W] == '0) && (code_y[m*CODE_W +: CODE_W] == '0) &&
          (code_ref[m*CODE_W +: CODE_W] == '1));
    end
  endgenerate
endmodule

bind dacfe_top dacfe_chk #(.NUM_MOD(NUM_MOD), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .por_n(por_n), .rst_act(rst_act),
  .code_x(code_x), .code_y(code_y), .code_ref(code_ref),
  .main_sh(main_sh_all), .ref_sh(ref_sh_all),
  .main_sck_r(main_sck_r), .main_ld_r(main_ld_r),
  .ref_sck_r(ref_sck_r), .ref_ld_r(ref_ld_r),
  .main_bit(main_bit), .ref_bit(ref_bit));

// File: tb/tb_dacfe_top.sv
module tb_dacfe_top;
  localparam int NM = 2;
  localparam int CW = 8;
  localparam int NV = 8;
  // vector fields: [31:24] module, [23:8] main word, [7:0] reference word
  localparam logic [31:0] VEC [NV] = '{
    32'h00_8001_80, 32'h01_0180_01, 32'h00_A55A_3C, 32'h01_FFFF_FF,
    32'h00_0000_00, 32'h01_1234_C7, 32'h00_F00F_5A, 32'h01_7EE7_81};

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic ext_rst_n = 1'b1;
  logic [NM-1:0] main_sck = '0, main_sdi = '0, main_ld = '0;
  logic [NM-1:0] ref_sck = '0, ref_sdi = '0, ref_ld = '0;
  logic [NM*CW-1:0] code_x, code_y, code_ref;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [CW-1:0] ex [NM];
  logic [CW-1:0] ey [NM];
  logic [CW-1:0] er [NM];

  always #4 clk = ~clk;

  dacfe_top #(.NUM_MOD(NM), .CODE_W(CW)) dut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
    .main_sck(main_sck), .main_sdi(main_sdi), .main_ld(main_ld),
    .ref_sck(ref_sck), .ref_sdi(ref_sdi), .ref_ld(ref_ld),
    .code_x(code_x), .code_y(code_y), .code_ref(code_ref));

  task automatic check(input logic [CW-1:0] got, input logic [CW-1:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int m = 0; m < NM; m++) begin
      check(code_x[m*CW +: CW], ex[m], {req, " code_x"});
      check(code_y[m*CW +: CW], ey[m], {req, " code_y"});
      check(code_ref[m*CW +: CW], er[m], {req, " code_ref"});
    end
  endtask

  task automatic reset_model();
    for (int m = 0; m < NM; m++) begin ex[m] = 8'h00; ey[m] = 8'h00; er[m] = 8'hFF; end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_main(input int m, input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      main_sdi[m] = w[i]; wait_clk(3);
      main_sck[m] = 1'b1; wait_clk(3);
      main_sck[m] = 1'b0;
    end
    wait_clk(3);
  endtask

  task automatic shift_ref(input int m, input logic [7:0] w);
    for (int i = 7; i >= 0; i--) begin
      ref_sdi[m] = w[i]; wait_clk(3);
      ref_sck[m] = 1'b1; wait_clk(3);
      ref_sck[m] = 1'b0;
    end
    wait_clk(3);
  endtask

  task automatic pulse_main_ld(input int m);
    main_ld[m] = 1'b1; wait_clk(4); main_ld[m] = 1'b0; wait_clk(3);
  endtask

  task automatic pulse_ref_ld(input int m);
    ref_ld[m] = 1'b1; wait_clk(4); ref_ld[m] = 1'b0; wait_clk(3);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    reset_model();
    wait_clk(3);
    check_all("R9 during power-on reset");
    por_n = 1'b1;
    wait_clk(5);
    check_all("R9 after power-on reset");

    // table walk: R1, R2, R4, R5, R8
    for (int v = 0; v < NV; v++) begin
      int m = int'(VEC[v][31:24]);
      logic [15:0] w = VEC[v][23:8];
      logic [7:0]  r = VEC[v][7:0];
      shift_main(m, {16'h0, w}, 16);
      shift_ref(m, r);
      check_all("R5 shifted without load");
      pulse_main_ld(m);
      ex[m] = w[15:8]; ey[m] = w[7:0];
      check_all("R1 R4 R8 main load");
      pulse_ref_ld(m);
      er[m] = r;
      check_all("R2 R8 reference load");
    end

    // R10: 24 bits shifted, only last 16 land
    shift_main(0, 32'h00C35A96, 24);
    pulse_main_ld(0);
    ex[0] = 8'h5A; ey[0] = 8'h96;
    check_all("R10 overlong stream");
    pulse_main_ld(0);
    check_all("R10 reload without clocks");
    // R3: four more bits on top of the held word
    shift_main(0, 32'h0000000B, 4);
    pulse_main_ld(0);
    ex[0] = 8'hA9; ey[0] = 8'h6B;
    check_all("R3 four extra bits");
    // R5: load pin held high leaves codes alone
    main_ld[1] = 1'b1; wait_clk(6);
    shift_main(1, 32'h0000FFFF, 16);
    check_all("R5 load held high");
    main_ld[1] = 1'b0; wait_clk(3);

    // R6: external reset, load edges ignored while low
    ext_rst_n = 1'b0; wait_clk(6);
    reset_model();
    check_all("R6 reset asserted");
    pulse_main_ld(1); pulse_ref_ld(0);
    check_all("R6 load during reset");
    ext_rst_n = 1'b1; wait_clk(6);
    check_all("R7 after release");
    shift_main(1, 32'h00003CC3, 16);
    shift_ref(1, 8'h42);
    check_all("R7 clocks without load");
    pulse_main_ld(1); pulse_ref_ld(1);
    ex[1] = 8'h3C; ey[1] = 8'hC3; er[1] = 8'h42;
    check_all("R4 R2 first load after reset");

    finish_up();
  end
endmodule